// File: doc/BRIEF.md
# Serial Peripheral Control Register with Synchronized Enable and Reset

This block is the bus-facing control slice of a serial peripheral. It stores a 32-bit configuration word that the serial engine reads as static settings: operating mode, frame format, pin routing and sampling. It also holds a small debug-control register. All registers are reached over an APB-style bus clocked by `pclk`.

Two bits of the control word act in a slower peripheral clock domain, `per_clk`: a run bit and a self-clearing software-reset bit. Neither takes effect at once. Each one starts a toggle handshake with two-flop synchronizers in both directions, and a busy flag stays raised until the peripheral domain has acknowledged.

A software reset takes precedence over everything else in its write. It clears the configuration, disables the engine and pulses a reset into the peripheral domain. Until the reset completes, any bus write is answered with an error. The configuration fields are locked while the run bit is set. The run bit and the reset bit stay writable at all times.

Top module: `ser_ctrl_reg`

## Requirements
- R1: After `presetn` is released, the control word (0x0) reads 0, the busy word (0x4) reads 0, `per_en_o` is 0 and `pslverr` is 0.
- R2: A write to 0x0 with bit 0 = 1 discards every other bit of that write. It clears control bits 31:1. In the peripheral domain it drives `per_en_o` to 0 and pulses `per_srst_o` for exactly one `per_clk` cycle. The debug register (0x8) keeps its contents.
- R3: Control bit 0 and busy bit 0 read 1 from the write that starts a reset until the peripheral domain acknowledges, then read 0. A control write with bit 0 = 0 never starts a reset.
- R4: While busy bit 0 is 1, every write gets `pslverr`=1 and changes no register. Reads get `pslverr`=0, and the debug register reads 0.
- R5: A control write with bit 0 = 0 made while busy bit 1 is 0 stores bit 1 (the run bit), which reads back on the next access. The same write sets busy bit 1. `per_en_o` then takes the stored value, after which busy bit 1 clears.
- R6: While busy bit 1 is 1, the run bit of a control write is ignored, and the stored run bit keeps its value.
- R7: While the stored run bit is 1, bits 31:2 of a control write are ignored, with no bus error. While the run bit is 0, they are stored as written.
- R8: The register map is:
  - 0x0: control word.
  - 0x4: busy word, read-only. Bit 0 is reset busy, bit 1 is run busy, other bits are 0.
  - 0x8: debug register, DBG_W bits.
  - Any other address, or an address with bits 1:0 not 0, reads 0 and ignores writes.

  `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | AW | Byte address |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error response for writes during reset |
| per_clk | input | 1 | Peripheral clock |
| per_rstn | input | 1 | Peripheral-domain reset, active low |
| cfg_o | output | DW | Stored configuration word |
| dbg_o | output | DBG_W | Debug register contents |
| busy_o | output | 2 | {run busy, reset busy} |
| per_en_o | output | 1 | Run enable in the peripheral domain |
| per_srst_o | output | 1 | One-cycle reset pulse in the peripheral domain |

## Verification
The hardest states to reach are the windows while a handshake is still in flight. One is a second run-bit write landing while the first is still busy. The other is bus traffic arriving during a software reset. The bench runs the peripheral clock at several times the bus period, so the acknowledge takes well over a hundred nanoseconds. It then issues back-to-back bus accesses straight after the triggering write, so that they land inside that window. Results are read back only after polling the busy word to zero.

// File: rtl/ser_ctrl_reg.sv
module ser_ctrl_reg #(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int DBG_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              per_clk,
  input  logic              per_rstn,
  output logic [DW-1:0]     cfg_o,
  output logic [DBG_W-1:0]  dbg_o,
  output logic [1:0]        busy_o,
  output logic              per_en_o,
  output logic              per_srst_o
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] IDX_CTRL = IW'(0);
  localparam logic [IW-1:0] IDX_BUSY = IW'(1);
  localparam logic [IW-1:0] IDX_DBG  = IW'(2);

  logic [DW-1:0]     ctrl_q;
  logic [DBG_W-1:0]  dbg_q;
  logic              en_req, rst_req;
  logic [SYNC_N-1:0] en_ack_s, rst_ack_s;
  logic [SYNC_N-1:0] en_req_s, rst_req_s;
  logic              en_ack_p, rst_ack_p, per_en_q, per_srst_q;

  wire           aligned  = (paddr[1:0] == 2'b00);
  wire [IW-1:0]  idx      = paddr[AW-1:2];
  wire           wr       = psel & penable & pwrite;
  wire           rst_busy = rst_req ^ rst_ack_s[SYNC_N-1];
  wire           en_busy  = en_req ^ en_ack_s[SYNC_N-1];
  wire           en_edge  = en_req_s[SYNC_N-1] ^ en_ack_p;
  wire           rst_edge = rst_req_s[SYNC_N-1] ^ rst_ack_p;

  assign pready     = 1'b1;
  assign pslverr    = wr & rst_busy;
  assign cfg_o      = ctrl_q;
  assign dbg_o      = dbg_q;
  assign busy_o     = {en_busy, rst_busy};
  assign per_en_o   = per_en_q;
  assign per_srst_o = per_srst_q;

  always_comb begin
    prdata = '0;
    if (aligned) begin
      case (idx)
        IDX_CTRL: prdata = {ctrl_q[DW-1:1], rst_busy};
        IDX_BUSY: prdata = DW'({en_busy, rst_busy});
        IDX_DBG:  prdata = rst_busy ? '0 : DW'(dbg_q);
        default:  prdata = '0;
      endcase
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q  <= '0;
      dbg_q   <= '0;
      en_req  <= 1'b0;
      rst_req <= 1'b0;
    end else if (wr && !rst_busy && aligned) begin
      if (idx == IDX_CTRL) begin
        if (pwdata[0]) begin
          ctrl_q  <= '0;
          rst_req <= ~rst_req;
        end else begin
          if (!ctrl_q[1]) ctrl_q[DW-1:2] <= pwdata[DW-1:2];
          if (!en_busy) begin
            ctrl_q[1] <= pwdata[1];
            en_req    <= ~en_req;
          end
        end
      end else if (idx == IDX_DBG) begin
        dbg_q <= pwdata[DBG_W-1:0];
      end
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en_ack_s  <= '0;
      rst_ack_s <= '0;
    end else begin
      en_ack_s  <= {en_ack_s[SYNC_N-2:0], en_ack_p};
      rst_ack_s <= {rst_ack_s[SYNC_N-2:0], rst_ack_p};
    end
  end

  always_ff @(posedge per_clk or negedge per_rstn) begin
    if (!per_rstn) begin
      en_req_s   <= '0;
      rst_req_s  <= '0;
      en_ack_p   <= 1'b0;
      rst_ack_p  <= 1'b0;
      per_en_q   <= 1'b0;
      per_srst_q <= 1'b0;
    end else begin
      en_req_s   <= {en_req_s[SYNC_N-2:0], en_req};
      rst_req_s  <= {rst_req_s[SYNC_N-2:0], rst_req};
      en_ack_p   <= en_req_s[SYNC_N-1];
      rst_ack_p  <= rst_req_s[SYNC_N-1];
      per_srst_q <= rst_edge;
      if (rst_edge)     per_en_q <= 1'b0;
      else if (en_edge) per_en_q <= ctrl_q[1];
    end
  end
endmodule

module ser_ctrl_reg_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          pclk,
  input logic          presetn,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] pwdata,
  input logic          pslverr,
  input logic [DW-1:0] cfg_o,
  input logic [1:0]    busy_o,
  input logic          per_clk,
  input logic          per_rstn,
  input logic          per_en_o,
  input logic          per_srst_o
);
  wire wr_acc  = psel && penable && pwrite;
  wire ctrl_wr = wr_acc && (paddr == '0);

  AST_RST_CLEARS_CFG: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(busy_o[0]) |-> cfg_o[DW-1:1] == '0); // R2
  AST_SRST_DISABLES: assert property (@(posedge per_clk) disable iff (!per_rstn)
    per_srst_o |-> !per_en_o); // R2
  AST_SRST_ONE_CYCLE: assert property (@(posedge per_clk) disable iff (!per_rstn)
    per_srst_o |=> !per_srst_o); // R2
  AST_WR_IN_RST_HOLDS: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_acc && busy_o[0]) |=> $stable(cfg_o)); // R4
  AST_ERR_ONLY_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (wr_acc && busy_o[0])); // R4
  AST_RUN_BUSY_SETS: assert property (@(posedge pclk) disable iff (!presetn)
    (ctrl_wr && !pwdata[0] && busy_o == 2'b00) |=> busy_o[1]); // R5
  AST_RUN_BIT_HELD: assert property (@(posedge pclk) disable iff (!presetn)
    (ctrl_wr && !pwdata[0] && busy_o == 2'b10) |=> cfg_o[1] == $past(cfg_o[1])); // R6
  AST_FIELDS_LOCKED: assert property (@(posedge pclk) disable iff (!presetn)
    (ctrl_wr && !pwdata[0] && cfg_o[1] && !busy_o[0]) |=> cfg_o[DW-1:2] == $past(cfg_o[DW-1:2])); // R7
endmodule

bind ser_ctrl_reg ser_ctrl_reg_chk #(.DW(DW), .AW(AW)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pslverr(pslverr), .cfg_o(cfg_o), .busy_o(busy_o),
  .per_clk(per_clk), .per_rstn(per_rstn), .per_en_o(per_en_o), .per_srst_o(per_srst_o)
);

// File: tb/test_ser_ctrl_reg.sv
`timescale 1ns/1ps
module test_ser_ctrl_reg;
  logic        pclk = 0, per_clk = 0, presetn = 0, per_rstn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, cfg_o;
  logic [7:0]  dbg_o;
  logic [1:0]  busy_o;
  logic        pready, pslverr, per_en_o, per_srst_o;
  int checks = 0, errors = 0, srst_pulses = 0;
  logic done = 0;

  always #5  pclk = ~pclk;
  always #35 per_clk = ~per_clk;

  ser_ctrl_reg i_ser_ctrl_reg (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .per_clk(per_clk), .per_rstn(per_rstn), .cfg_o(cfg_o), .dbg_o(dbg_o),
    .busy_o(busy_o), .per_en_o(per_en_o), .per_srst_o(per_srst_o)
  );

  always @(posedge per_clk) if (per_srst_o) srst_pulses++;

  // {write data, expected control readback, expected per_en_o}
  localparam logic [64:0] VEC [5] = '{
    {32'hA5A5_A5A4, 32'hA5A5_A5A4, 1'b0},
    {32'h0000_0F02, 32'h0000_0F02, 1'b1},
    {32'hFFFF_FFFC, 32'h0000_0F00, 1'b0},
    {32'h1234_5678, 32'h1234_5678, 1'b0},
    {32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [3:0] a, input logic [31:0] d, output logic err);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1; #1 err = pslverr;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [3:0] a, output logic [31:0] d, output logic err);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata; err = pslverr;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] d; logic e;
    for (int i = 0; i < 300; i++) begin
      apb_rd(4'h4, d, e);
      if (d == 0) return;
    end
    check("R5 busy never cleared", d, 0);
  endtask

  initial begin
    logic [31:0] d; logic e;
    repeat (3) @(negedge pclk);
    presetn = 1; per_rstn = 1;
    // R1 reset state
    apb_rd(4'h0, d, e); check("R1 ctrl", d, 0);
    apb_rd(4'h4, d, e); check("R1 busy", d, 0);
    check("R1 per_en", {31'b0, per_en_o}, 0);
    check("R1 pslverr", {31'b0, e}, 0);
    // R8 map
    apb_rd(4'hC, d, e); check("R8 unmapped", d, 0);
    apb_rd(4'h1, d, e); check("R8 misaligned", d, 0);
    check("R8 pready", {31'b0, pready}, 1);
    // vector loop: R5 readback, R7 protection
    foreach (VEC[i]) begin
      apb_wr(4'h0, VEC[i][64:33], e);
      apb_rd(4'h0, d, e); check("R7 ctrl readback", d, VEC[i][32:1]);
      wait_idle();
      check("R5 per_en after handshake", {31'b0, per_en_o}, {31'b0, VEC[i][0]});
    end
    // R6 run bit ignored while busy
    apb_wr(4'h0, 32'h2, e);
    apb_wr(4'h0, 32'h0, e);
    apb_rd(4'h0, d, e); check("R6 run bit held", d, 32'h2);
    wait_idle();
    check("R5 per_en on", {31'b0, per_en_o}, 1);
    apb_wr(4'h0, 32'h0, e);
    apb_rd(4'h4, d, e); check("R5 run busy set", d, 32'h2);
    check("R5 per_en not yet off", {31'b0, per_en_o}, 1);
    wait_idle();
    check("R5 per_en off", {31'b0, per_en_o}, 0);
    // R8 debug register
    apb_wr(4'h8, 32'h5A, e);
    apb_rd(4'h8, d, e); check("R8 dbg", d, 32'h5A);
    apb_wr(4'h4, 32'hFF, e);
    apb_rd(4'h4, d, e); check("R8 busy word read-only", d, 0);
    apb_wr(4'h0, 32'h3302, e);
    wait_idle();
    check("R5 enabled before reset", {31'b0, per_en_o}, 1);
    // R2/R3/R4 software reset
    apb_wr(4'h0, 32'hFFFF_FFFF, e); check("R2 reset write no error", {31'b0, e}, 0);
    apb_rd(4'h0, d, e); check("R3 ctrl during reset", d, 32'h1);
    apb_rd(4'h4, d, e); check("R3 reset busy", d & 32'h1, 32'h1);
    apb_wr(4'h8, 32'h11, e); check("R4 write error", {31'b0, e}, 1);
    apb_rd(4'h8, d, e); check("R4 dbg reads zero", d, 0);
    check("R4 read no error", {31'b0, e}, 0);
    wait_idle();
    apb_rd(4'h0, d, e); check("R3 ctrl after reset", d, 0);
    apb_rd(4'h8, d, e); check("R2 dbg kept", d, 32'h5A);
    check("R2 per_en cleared", {31'b0, per_en_o}, 0);
    check("R2 one srst pulse", srst_pulses, 1);
    // R3 writing 0 to reset bit starts no reset
    apb_wr(4'h0, 32'h0000_0400, e);
    apb_rd(4'h4, d, e); check("R3 no reset started", d, 32'h2);
    wait_idle();
    apb_rd(4'h0, d, e); check("R3 ctrl written", d, 32'h0000_0400);
    check("R2 srst count unchanged", srst_pulses, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule